// File: doc/BRIEF.md
# Parallel Instruction Length Decoder

This block takes a window of consecutive 32-bit code words from the fetch buffer and cuts it into instructions that are one, two or three words long. Each instruction's size is read only from a two-bit code in its first word. No other bit plays a part. Starting at an offset supplied by the fetch logic, the block resolves up to four instruction boundaries in the same cycle. It reports a descriptor for each one, holding the start position, the length and a valid flag. It also reports how many words those descriptors cover, so the fetch buffer can advance by that amount.

The boundaries are found through a chain of per-slot lookups. Every word of the window is first given its own length, its own "next start" position and its own "complete and valid" flag, all in parallel. Each slot then only selects entries from these precomputed tables, based on the position handed on by the previous slot. An instruction that runs past the end of the window, or that covers a word not flagged valid, is not reported. It is left for the next window. All results are registered.

Top module: `instr_len_decoder`

## Requirements
- R1: The length of an instruction comes from bits 31:30 of its first word: code 00 or 01 gives one word, 10 gives two words and 11 gives three words. A valid descriptor carries that length (1, 2 or 3) in its two-bit length field.
- R2: The first descriptor slot (slot 0) starts at the word offset given on `in_start`.
- R3: Each later slot starts at the word that directly follows the last word of the instruction in the slot before it.
- R4: A descriptor is valid only if every word of its instruction lies inside the eight-word window and has its bit in `in_wvalid` set. An instruction that crosses the window end is not reported.
- R5: Once a slot is invalid, every later slot in the same result is invalid, even if its words would be complete.
- R6: `out_used` equals the sum of the lengths of the valid descriptors.
- R7: Bits 29:0 of a word have no effect on any output.
- R8: All outputs are registered. The result for the inputs present at a rising clock edge appears just after that edge. While `rst_n` is low, every output is zero. The offset and length fields of an invalid slot read zero.
- R9: At most four descriptors are reported per cycle. Words beyond the fourth instruction are not counted in `out_used`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_words | input | 256 | Window of eight 32-bit words; word i is bits [32*i+31:32*i] |
| in_wvalid | input | 8 | Per-word valid flags; bit i belongs to word i |
| in_start | input | 3 | Word offset of the first instruction in the window |
| out_vld | output | 4 | Descriptor valid flags; bit k belongs to slot k |
| out_off | output | 12 | Start offsets, 3 bits per slot; slot k is bits [3*k+2:3*k] |
| out_len | output | 8 | Lengths in words, 2 bits per slot; slot k is bits [2*k+1:2*k] |
| out_used | output | 4 | Number of words covered by the valid descriptors |

## Verification
Every output is due exactly one rising edge after the inputs that produce it. The bench therefore drives a new window on a falling edge and computes the expected descriptors at that moment, from a behavioural walk over the window. It compares all outputs at the next falling edge, after the single register stage has loaded. A fresh window is applied on every clock, so each result is checked in the one cycle it is visible. The reset checks sample the outputs on a falling edge while `rst_n` is held low.

// File: rtl/ild_pkg.sv
package ild_pkg;
  localparam int LEN_W  = 2;
  localparam int MAXLEN = 3;

  // Two-bit length code taken from bits 31:30 of a first word.
  function automatic logic [LEN_W-1:0] code_to_len(input logic [1:0] code);
    case (code)
      2'b10:   return 2'd2;
      2'b11:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/ild_word_scan.sv
module ild_word_scan #(
  parameter int WIN    = 8,
  parameter int WORD_W = 32,
  parameter int POS_W  = 5
) (
  input  logic [WIN*WORD_W-1:0]              words,
  input  logic [WIN-1:0]                     wvalid,
  output logic [WIN*ild_pkg::LEN_W-1:0]      wlen,
  output logic [WIN-1:0]                     wok,
  output logic [WIN*POS_W-1:0]               wnext
);
  import ild_pkg::*;

  // Flags padded with zeros: words past the window end never count as present.
  logic [WIN+MAXLEN-1:0] vpad;
  assign vpad = {{MAXLEN{1'b0}}, wvalid};

  for (genvar w = 0; w < WIN; w++) begin : g_word
    logic [LEN_W-1:0] len_w;
    logic             ok_w;

    assign len_w = code_to_len(words[w*WORD_W + WORD_W-1 -: 2]);

    always_comb begin
      ok_w = 1'b1;
      for (int j = 0; j < MAXLEN; j++) begin
        if (j < int'(len_w)) ok_w = ok_w & vpad[w+j];
      end
    end

    assign wlen[w*LEN_W +: LEN_W]  = len_w;
    assign wok[w]                  = ok_w;
    assign wnext[w*POS_W +: POS_W] = POS_W'(w) + POS_W'(len_w);
  end
endmodule

// File: rtl/ild_slot_chain.sv
module ild_slot_chain #(
  parameter int WIN   = 8,
  parameter int SLOTS = 4,
  parameter int OFF_W = 3,
  parameter int POS_W = 5,
  parameter int CNT_W = 4
) (
  input  logic [OFF_W-1:0]                 start,
  input  logic [WIN*ild_pkg::LEN_W-1:0]    wlen,
  input  logic [WIN-1:0]                   wok,
  input  logic [WIN*POS_W-1:0]             wnext,
  output logic [SLOTS-1:0]                 vld,
  output logic [SLOTS*OFF_W-1:0]           off,
  output logic [SLOTS*ild_pkg::LEN_W-1:0]  len,
  output logic [CNT_W-1:0]                 used
);
  import ild_pkg::*;

  logic [POS_W-1:0] pos  [SLOTS+1];
  logic             live [SLOTS+1];

  assign pos[0]  = POS_W'(start);
  assign live[0] = 1'b1;

  // Each slot only selects entries from the per-word tables.
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic             in_win;
    logic [OFF_W-1:0] idx;
    logic             take;

    assign in_win    = pos[k] < POS_W'(WIN);
    assign idx       = in_win ? pos[k][OFF_W-1:0] : '0;
    assign take      = live[k] && in_win && wok[idx];
    assign live[k+1] = take;
    assign pos[k+1]  = take ? wnext[idx*POS_W +: POS_W] : pos[k];

    assign vld[k]                  = take;
    assign off[k*OFF_W +: OFF_W]   = take ? idx : '0;
    assign len[k*LEN_W +: LEN_W]   = take ? wlen[idx*LEN_W +: LEN_W] : '0;
  end

  assign used = CNT_W'(pos[SLOTS] - POS_W'(start));
endmodule

// File: rtl/instr_len_decoder.sv
module instr_len_decoder #(
  parameter int WIN    = 8,
  parameter int WORD_W = 32,
  parameter int SLOTS  = 4,
  localparam int OFF_W = $clog2(WIN),
  localparam int POS_W = OFF_W + 2,
  localparam int CNT_W = $clog2(WIN + 1),
  localparam int LEN_W = ild_pkg::LEN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WIN*WORD_W-1:0]   in_words,
  input  logic [WIN-1:0]          in_wvalid,
  input  logic [OFF_W-1:0]        in_start,
  output logic [SLOTS-1:0]        out_vld,
  output logic [SLOTS*OFF_W-1:0]  out_off,
  output logic [SLOTS*LEN_W-1:0]  out_len,
  output logic [CNT_W-1:0]        out_used
);
  logic [WIN*LEN_W-1:0]   wlen;
  logic [WIN-1:0]         wok;
  logic [WIN*POS_W-1:0]   wnext;
  logic [SLOTS-1:0]       nx_vld;
  logic [SLOTS*OFF_W-1:0] nx_off;
  logic [SLOTS*LEN_W-1:0] nx_len;
  logic [CNT_W-1:0]       nx_used;

  ild_word_scan #(.WIN(WIN), .WORD_W(WORD_W), .POS_W(POS_W)) u_scan (
    .words (in_words),
    .wvalid(in_wvalid),
    .wlen  (wlen),
    .wok   (wok),
    .wnext (wnext)
  );

  ild_slot_chain #(.WIN(WIN), .SLOTS(SLOTS), .OFF_W(OFF_W), .POS_W(POS_W),
                   .CNT_W(CNT_W)) u_chain (
    .start(in_start),
    .wlen (wlen),
    .wok  (wok),
    .wnext(wnext),
    .vld  (nx_vld),
    .off  (nx_off),
    .len  (nx_len),
    .used (nx_used)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= '0;
      out_off  <= '0;
      out_len  <= '0;
      out_used <= '0;
    end else begin
      out_vld  <= nx_vld;
      out_off  <= nx_off;
      out_len  <= nx_len;
      out_used <= nx_used;
    end
  end

  // Sum of the registered lengths, formed apart from the position chain.
  logic [CNT_W+1:0] chk_sum;
  always_comb begin
    chk_sum = '0;
    for (int k = 0; k < SLOTS; k++)
      if (out_vld[k]) chk_sum = chk_sum + (CNT_W+2)'(out_len[k*LEN_W +: LEN_W]);
  end

  assert_used_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W+2)'(out_used) == chk_sum);

  assert_first_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld[0] |-> out_off[OFF_W-1:0] == $past(in_start));

  for (genvar k = 0; k < SLOTS; k++) begin : g_chk
    assert_len_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[k] |-> out_len[k*LEN_W +: LEN_W] != 2'd0);

    assert_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[k] |-> (POS_W'(out_off[k*OFF_W +: OFF_W])
                      + POS_W'(out_len[k*LEN_W +: LEN_W])) <= POS_W'(WIN));

    if (k > 0) begin : g_link
      assert_adjacent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld[k] |-> POS_W'(out_off[k*OFF_W +: OFF_W]) ==
          POS_W'(out_off[(k-1)*OFF_W +: OFF_W]) + POS_W'(out_len[(k-1)*LEN_W +: LEN_W]));

      assert_stop_after_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld[k-1] |-> !out_vld[k]);
    end
  end
endmodule

// File: tb/tb_instr_len_decoder.sv
module tb_instr_len_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [255:0]  in_words = '0;
  logic [7:0]    in_wvalid = '0;
  logic [2:0]    in_start = '0;
  logic [3:0]    out_vld;
  logic [11:0]   out_off;
  logic [7:0]    out_len;
  logic [3:0]    out_used;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int e_vld [NS];
  int e_off [NS];
  int e_len [NS];
  int e_used;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_len_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_words(in_words), .in_wvalid(in_wvalid),
    .in_start(in_start), .out_vld(out_vld), .out_off(out_off),
    .out_len(out_len), .out_used(out_used)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model: walk the window one instruction at a time.
  task automatic model();
    int p = int'(in_start);
    bit stop = 0;
    e_used = 0;
    for (int k = 0; k < NS; k++) begin
      e_vld[k] = 0; e_off[k] = 0; e_len[k] = 0;
      if (!stop) begin
        int code;
        int n;
        bit whole;
        if (p >= NW) stop = 1;
        else begin
          code = int'(in_words[32*p+30 +: 2]);
          n = (code >= 2) ? code : 1;
          whole = (p + n <= NW);
          for (int q = p; q < p + n; q++) if (q >= NW || !in_wvalid[q]) whole = 0;
          if (!whole) stop = 1;
          else begin
            e_vld[k] = 1; e_off[k] = p; e_len[k] = n;
            e_used += n; p += n;
          end
        end
      end
    end
  endtask

  task automatic compare(input string ctx);
    for (int k = 0; k < NS; k++) begin
      int av = int'(out_vld[k]);
      int ao = int'(out_off[3*k +: 3]);
      int al = int'(out_len[2*k +: 2]);
      check(av == e_vld[k], $sformatf("R4/R5 %s slot%0d vld", ctx, k), av, e_vld[k]);
      check(ao == e_off[k], $sformatf("%s %s slot%0d off", (k == 0) ? "R2" : "R3", ctx, k), ao, e_off[k]);
      check(al == e_len[k], $sformatf("R1 %s slot%0d len", ctx, k), al, e_len[k]);
    end
    check(int'(out_used) == e_used, $sformatf("R6/R9 %s used", ctx), int'(out_used), e_used);
  endtask

  // Drive at a falling edge, result due after the next rising edge.
  task automatic apply(input logic [255:0] w, input logic [7:0] v, input int s, input string ctx);
    in_words = w; in_wvalid = v; in_start = 3'(s);
    model();
    @(negedge clk);
    compare(ctx);
  endtask

  function automatic logic [255:0] fill(input logic [1:0] codes [NW], input bit noisy);
    logic [255:0] r = '0;
    for (int i = 0; i < NW; i++)
      r[32*i +: 32] = {codes[i], noisy ? 30'($urandom) : 30'h0};
    return r;
  endfunction

  task automatic check_zero(input string ctx);
    check(out_vld == '0,  {"R8 ", ctx, " vld"},  int'(out_vld), 0);
    check(out_off == '0,  {"R8 ", ctx, " off"},  int'(out_off), 0);
    check(out_len == '0,  {"R8 ", ctx, " len"},  int'(out_len), 0);
    check(out_used == '0, {"R8 ", ctx, " used"}, int'(out_used), 0);
  endtask

  initial begin
    logic [1:0] c [NW];
    repeat (3) @(negedge clk);
    check_zero("reset");
    rst_n = 1'b1;

    // R1 R9: one-word codes, four slots cap the count
    c = '{2'b00, 2'b01, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00};
    apply(fill(c, 0), 8'hFF, 0, "short");
    // R4: three-word instructions, third crosses the window end
    c = '{default: 2'b11};
    apply(fill(c, 0), 8'hFF, 0, "long_cross");
    // R2 R4: start 5, second two-word instruction needs word 8
    c = '{default: 2'b10};
    apply(fill(c, 0), 8'hFF, 5, "start5");
    // R5: hole at word 2 stops the chain though word 3 is present
    c = '{default: 2'b00};
    apply(fill(c, 0), 8'b1111_1011, 0, "hole");
    // R3: mixed lengths
    c = '{2'b10, 2'b00, 2'b01, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11};
    apply(fill(c, 0), 8'hFF, 0, "mixed");
    // R4: second word of a two-word instruction missing
    c = '{default: 2'b10};
    apply(fill(c, 0), 8'b1111_1101, 0, "tail_missing");
    // R2: last word alone
    c = '{default: 2'b00};
    apply(fill(c, 0), 8'hFF, 7, "start7");
    // R7: same codes, noisy low bits
    c = '{2'b10, 2'b00, 2'b01, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11};
    apply(fill(c, 1), 8'hFF, 0, "R7_noise_a");
    apply(fill(c, 1), 8'hFF, 0, "R7_noise_b");
    // nothing valid
    apply(fill(c, 0), 8'h00, 0, "empty");

    for (int i = 0; i < 400; i++) begin
      logic [255:0] w;
      logic [7:0] v;
      for (int j = 0; j < NW; j++) begin
        w[32*j +: 32] = $urandom;
        v[j] = ($urandom % 8) != 0;
      end
      apply(w, v, int'($urandom % 8), "random");
    end

    // R8: reset clears outputs mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check_zero("mid_reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule